// File: doc/BRIEF.md
# Receive Sample-Delay Mapper

This block computes how many phase steps the receive sampling clock of an SD card host is delayed, relative to the transmit clock. It adds three terms: a programmable base delay, a small extra offset, and a contribution from the 4-bit tuning code that the host controller moves during its tuning sweep. The tuning code is used directly as a step count, stretched in proportion over one whole clock cycle of the active step count, or ignored, depending on the map mode.

A sum that reaches or passes one cycle (the steps-per-cycle input) is then wrapped, clamped to the last step, or flagged as failed, as chosen by an overflow policy. A failure sets a sticky flag. While that flag is up, the last good delay stays on the output, and software clears the flag with a one-cycle clear pulse. A bypass input forces the delay to zero. A new tuning code is taken only on an update strobe. One cycle later the block pulses an updated signal, so the host knows the new delay is in effect. The block outputs only the delay count; the clock generator that uses it lies outside.

Top module: `rx_sample_delay`

## Requirements
- R1: After reset, actual_delay is 0, fail_actual is 0, delay_updated is 0 and the held tuning code is 0.
- R2: With map_mode 0, the delay registered on the next clock edge is base_delay + offset + held tuning code, when that sum is below steps_per_cycle.
- R3: With map_mode 2, the tuning term is floor(tuning code × steps_per_cycle / 16).
- R4: With map_mode 1 or 3, the tuning code adds nothing.
- R5: The tuning code is loaded from tune_sel only in a cycle where tune_upd is 1, and that cycle already uses the new code. Changes to tune_sel at other times have no effect.
- R6: delay_updated is 1 for exactly the cycle after a tune_upd cycle, unless fail_actual is 1 after that same edge.
- R7: ovf_policy 0: a sum at or above steps_per_cycle is output as sum modulo steps_per_cycle.
- R8: ovf_policy 1: a sum at or above steps_per_cycle is output as steps_per_cycle − 1.
- R9: ovf_policy 2 or 3: a sum at or above steps_per_cycle sets fail_actual. The flag stays set until it is cleared.
- R10: While fail_actual is set, actual_delay keeps its last value. fail_clr=1 clears the flag, unless the same cycle raises a new failure.
- R11: bypass=1 forces actual_delay to 0 on the next edge and raises no new failure.
- R12: steps_per_cycle is assumed to be one of 4, 5, 6, 8, 10, 12, 16, 20. Every output is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| steps_per_cycle | input | 5 | Phase steps in one clock cycle (4..20) |
| map_mode | input | 2 | 0 direct, 2 stretch, 1/3 tuning ignored |
| ovf_policy | input | 2 | 0 wrap, 1 clamp, 2/3 fail |
| base_delay | input | 5 | Base delay in steps (typical 6) |
| offset | input | 2 | Extra steps added |
| tune_sel | input | 4 | Tuning code from the host |
| tune_upd | input | 1 | Strobe that loads tune_sel |
| bypass | input | 1 | Force zero delay |
| fail_clr | input | 1 | Clears the fail flag |
| actual_delay | output | 5 | Applied delay in steps |
| fail_actual | output | 1 | Sticky overflow failure flag |
| delay_updated | output | 1 | One-cycle pulse after a tuning load |

## Verification
Several properties are checked on every clock: the delay stays below one cycle when the policy is wrap or clamp and no failure is pending; the fail flag holds until it is cleared; the delay is frozen while a failure is pending; bypass gives zero; and the updated pulse only follows a strobe. The exact arithmetic cannot be checked by a property without copying the datapath. This covers the proportional stretch values, the modulo wrap results, the exact clamp value, and ignoring tune_sel between strobes. These are shown only by the bench. Its scenarios compare each cycle against a behavioural model, over directed corner cases and random mixes of step counts, modes and policies.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
    localparam int DLY_W  = 5;
    localparam int OFS_W  = 2;
    localparam int TUNE_W = 4;
    localparam int SUM_W  = DLY_W + 2;
    localparam int PROD_W = TUNE_W + DLY_W;

    localparam logic [1:0] MAP_DIRECT  = 2'd0;
    localparam logic [1:0] MAP_STRETCH = 2'd2;
    localparam logic [1:0] POL_WRAP    = 2'd0;
    localparam logic [1:0] POL_CLAMP   = 2'd1;

    typedef struct packed {
        logic [TUNE_W-1:0] tune;
        logic [DLY_W-1:0]  actual;
        logic              fail;
        logic              updated;
    } rxd_state_t;
endpackage

// File: rtl/rxd_tune_map.sv
`timescale 1ns/1ps
module rxd_tune_map
    import rxd_pkg::*;
(
    input  logic [TUNE_W-1:0] tune,
    input  logic [DLY_W-1:0]  steps,
    input  logic [1:0]        mode,
    output logic [SUM_W-1:0]  contrib
);
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = {{DLY_W{1'b0}}, tune} * {{TUNE_W{1'b0}}, steps};
        case (mode)
            MAP_DIRECT:  contrib = SUM_W'(tune);
            MAP_STRETCH: contrib = SUM_W'(prod >> TUNE_W);
            default:     contrib = '0;
        endcase
    end
endmodule

// File: rtl/rxd_overflow.sv
`timescale 1ns/1ps
module rxd_overflow
    import rxd_pkg::*;
(
    input  logic [SUM_W-1:0] raw,
    input  logic [DLY_W-1:0] steps,
    input  logic [1:0]       policy,
    output logic [DLY_W-1:0] result,
    output logic             fail_evt
);
    logic [SUM_W-1:0] steps_ext;
    logic [SUM_W-1:0] wrapped;
    logic             over;

    always_comb begin
        steps_ext = SUM_W'(steps);
        over      = (raw >= steps_ext);
        wrapped   = (steps_ext != '0) ? (raw % steps_ext) : '0;
        fail_evt  = 1'b0;
        result    = raw[DLY_W-1:0];
        if (over) begin
            case (policy)
                POL_WRAP:  result = wrapped[DLY_W-1:0];
                POL_CLAMP: result = steps - 1'b1;
                default: begin
                    result   = '0;
                    fail_evt = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_sample_delay.sv
`timescale 1ns/1ps
module rx_sample_delay
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  steps_per_cycle,
    input  logic [1:0]        map_mode,
    input  logic [1:0]        ovf_policy,
    input  logic [DLY_W-1:0]  base_delay,
    input  logic [OFS_W-1:0]  offset,
    input  logic [TUNE_W-1:0] tune_sel,
    input  logic              tune_upd,
    input  logic              bypass,
    input  logic              fail_clr,
    output logic [DLY_W-1:0]  actual_delay,
    output logic              fail_actual,
    output logic              delay_updated
);
    rxd_state_t        st_d, st_q;
    logic [TUNE_W-1:0] tune_eff;
    logic [SUM_W-1:0]  contrib;
    logic [SUM_W-1:0]  raw_sum;
    logic [DLY_W-1:0]  mapped;
    logic              fail_evt;

    assign tune_eff = tune_upd ? tune_sel : st_q.tune;
    assign raw_sum  = SUM_W'(base_delay) + SUM_W'(offset) + contrib;

    rxd_tune_map u_map (
        .tune    (tune_eff),
        .steps   (steps_per_cycle),
        .mode    (map_mode),
        .contrib (contrib)
    );

    rxd_overflow u_ovf (
        .raw      (raw_sum),
        .steps    (steps_per_cycle),
        .policy   (ovf_policy),
        .result   (mapped),
        .fail_evt (fail_evt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tune = tune_eff;
        st_d.fail = (st_q.fail & ~fail_clr) | (fail_evt & ~bypass);
        if (bypass)
            st_d.actual = '0;
        else if (!st_d.fail)
            st_d.actual = mapped;
        st_d.updated = tune_upd & ~st_d.fail;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign actual_delay  = st_q.actual;
    assign fail_actual   = st_q.fail;
    assign delay_updated = st_q.updated;

    // R11
    bypass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (actual_delay == '0));
    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_actual && !fail_clr) |=> fail_actual);
    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_actual && !fail_clr && !bypass) |=> $stable(actual_delay));
    // R6
    upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delay_updated |-> $past(tune_upd));
    // R7 R8
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_policy[1] && (!fail_actual || fail_clr)) |=>
            (actual_delay < $past(steps_per_cycle)));
endmodule

// File: tb/sim_rx_sample_delay.sv
`timescale 1ns/1ps
module sim_rx_sample_delay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] steps_per_cycle = 5'd20;
    logic [1:0] map_mode = 2'd0;
    logic [1:0] ovf_policy = 2'd0;
    logic [4:0] base_delay = 5'd0;
    logic [1:0] offset = 2'd0;
    logic [3:0] tune_sel = 4'd0;
    logic       tune_upd = 1'b0;
    logic       bypass = 1'b0;
    logic       fail_clr = 1'b0;
    logic [4:0] actual_delay;
    logic       fail_actual;
    logic       delay_updated;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit running = 1'b0;

    int m_tune = 0, m_act = 0, m_fail = 0, m_upd = 0;

    always #10 clk = ~clk;

    rx_sample_delay u0 (
        .clk(clk), .rst_n(rst_n), .steps_per_cycle(steps_per_cycle),
        .map_mode(map_mode), .ovf_policy(ovf_policy), .base_delay(base_delay),
        .offset(offset), .tune_sel(tune_sel), .tune_upd(tune_upd),
        .bypass(bypass), .fail_clr(fail_clr), .actual_delay(actual_delay),
        .fail_actual(fail_actual), .delay_updated(delay_updated)
    );

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // behavioural reference
    always @(posedge clk) begin
        int eff, add, sum, st;
        bit over, newfail;
        if (!rst_n) begin
            m_tune = 0; m_act = 0; m_fail = 0; m_upd = 0;
        end else begin
            st  = steps_per_cycle;
            eff = tune_upd ? int'(tune_sel) : m_tune;
            if (map_mode == 0)      add = eff;
            else if (map_mode == 2) add = (eff * st) / 16;
            else                    add = 0;
            sum = int'(base_delay) + int'(offset) + add;
            over = (sum >= st);
            newfail = !bypass && over && (ovf_policy >= 2);
            m_fail = ((m_fail != 0) && !fail_clr) || newfail;
            if (bypass) m_act = 0;
            else if (m_fail == 0) begin
                if (!over)                m_act = sum;
                else if (ovf_policy == 0) m_act = sum % st;
                else                      m_act = st - 1;
            end
            m_upd = tune_upd && (m_fail == 0);
            m_tune = eff;
        end
    end

    always @(posedge clk) begin
        #1;
        if (running) begin
            check(cur_req, "actual_delay", actual_delay, m_act);
            check(cur_req, "fail_actual", fail_actual, m_fail);
            check(cur_req, "delay_updated", delay_updated, m_upd);
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic drv();
        @(negedge clk);
    endtask

    function automatic logic [4:0] pick_steps(int k);
        case (k % 8)
            0: return 5'd4;  1: return 5'd5;  2: return 5'd6;  3: return 5'd8;
            4: return 5'd10; 5: return 5'd12; 6: return 5'd16; default: return 5'd20;
        endcase
    endfunction

    initial begin
        repeat (3) cyc();
        // R1 reset values
        check("R1", "actual_delay in reset", actual_delay, 0);
        check("R1", "fail_actual in reset", fail_actual, 0);
        check("R1", "delay_updated in reset", delay_updated, 0);
        drv(); rst_n = 1'b1; running = 1'b1;
        cyc();
        check("R1", "held tuning code after reset", actual_delay, 0);

        // R2 / R6 direct mode with strobe
        drv(); cur_req = "R2"; base_delay = 6; offset = 1; ovf_policy = 1;
        tune_sel = 3; tune_upd = 1;
        cyc(); check("R2", "direct sum", actual_delay, 10);
        check("R6", "updated pulse", delay_updated, 1);
        // R5 tune_sel ignored without strobe
        drv(); cur_req = "R5"; tune_upd = 0; tune_sel = 9;
        cyc(); check("R5", "no strobe", actual_delay, 10);
        check("R6", "pulse ends", delay_updated, 0);
        // R3 stretch
        drv(); cur_req = "R3"; map_mode = 2; steps_per_cycle = 10;
        cyc(); check("R3", "stretch 3*10/16", actual_delay, 8);
        // R4 ignore
        drv(); cur_req = "R4"; map_mode = 1;
        cyc(); check("R4", "mode 1 ignores tuning", actual_delay, 7);
        drv(); map_mode = 3;
        cyc(); check("R4", "mode 3 ignores tuning", actual_delay, 7);
        // R7 wrap
        drv(); cur_req = "R7"; map_mode = 0; steps_per_cycle = 20; base_delay = 18;
        offset = 2; ovf_policy = 0;
        cyc(); check("R7", "wrap 23 mod 20", actual_delay, 3);
        // R8 clamp
        drv(); cur_req = "R8"; ovf_policy = 1;
        cyc(); check("R8", "clamp", actual_delay, 19);
        // R9 fail
        drv(); cur_req = "R9"; ovf_policy = 2;
        cyc(); check("R9", "fail set", fail_actual, 1);
        check("R9", "actual held", actual_delay, 19);
        // R10 hold while failed
        drv(); cur_req = "R10"; base_delay = 6; ovf_policy = 0;
        cyc(); check("R10", "fail sticky", fail_actual, 1);
        check("R10", "actual frozen", actual_delay, 19);
        drv(); fail_clr = 1;
        cyc(); check("R10", "cleared", fail_actual, 0);
        check("R10", "new delay", actual_delay, 11);
        // R11 bypass
        drv(); cur_req = "R11"; fail_clr = 0; bypass = 1; base_delay = 31; ovf_policy = 2;
        cyc(); check("R11", "bypass zero", actual_delay, 0);
        check("R11", "no fail in bypass", fail_actual, 0);
        // R6 strobe into failure gives no pulse
        drv(); cur_req = "R6"; bypass = 0; tune_sel = 0; tune_upd = 1;
        cyc(); check("R6", "no pulse on fail", delay_updated, 0);
        check("R9", "fail on 33", fail_actual, 1);
        drv(); tune_upd = 0; fail_clr = 1; base_delay = 6; ovf_policy = 1;
        cyc(); check("R10", "clear and reload", actual_delay, 8);
        drv(); fail_clr = 0;

        // R12 random mix against model
        cur_req = "R12";
        for (int i = 0; i < 600; i++) begin
            drv();
            steps_per_cycle = pick_steps($urandom);
            map_mode   = 2'($urandom);
            ovf_policy = 2'($urandom);
            base_delay = 5'($urandom);
            offset     = 2'($urandom);
            tune_sel   = 4'($urandom);
            tune_upd   = ($urandom % 3) == 0;
            bypass     = ($urandom % 8) == 0;
            fail_clr   = ($urandom % 4) == 0;
        end
        drv(); running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule